// File: doc/BRIEF.md
# VLIW Bundle Energy Accumulator

This block keeps a running energy estimate for a four-slot VLIW core while it runs. It watches the issue stage, and on every clock it sorts the core into one of four kinds of cycle: a bundle issue, a data-side stall, an instruction-fetch miss cycle (in which the core injects empty bundles), or an idle cycle. For each kind it adds a programmable cost to a fixed-point total.

The cost of an issued bundle is a base amount plus a per-operation amount times the number of slots that carry a real operation, not a NOP. Stall cycles and fetch-miss cycles each have a flat cost of their own. The total is therefore the sum of three separate parts: ideal execution, stalls and fetch misses. A counter for each of these three kinds records how many cycles went into it. Software sets the four cost coefficients through a small write port. It can zero the total and the counters with a synchronous clear, and then read the results to get an energy figure for each region of code.

Top module: `bundle_energy_meter`

## Requirements
- R1: A synchronous active-high `rst` sets the energy total, all three cycle counters and all four cost coefficients to zero. An issued bundle before any coefficient write therefore adds nothing.
- R2: When `cfg_we` is high at a clock edge, `cfg_wdata` is stored in the coefficient chosen by `cfg_addr`: 0 = bundle base cost, 1 = cost per real operation, 2 = stall cost, 3 = fetch-miss cost. The new value applies to cycles presented from the next edge on. A cycle presented in the same edge as the write still uses the old value.
- R3: A cycle with `issue_vld` high and both `dstall` and `imiss` low adds base + k × per-operation cost to the total, and adds 1 to `ideal_cnt`. Here k is the number of zero bits in `slot_nop`, where bit i = 1 marks slot i as a NOP.
- R4: A cycle with `dstall` high adds the stall cost and adds 1 to `stall_cnt`, whatever the values of `issue_vld` and `slot_nop`.
- R5: A cycle with `imiss` high and `dstall` low adds the fetch-miss cost and adds 1 to `imiss_cnt`, whatever the value of `issue_vld`.
- R6: When `dstall` and `imiss` are both high, only the stall cost is added and only `stall_cnt` advances. No cycle ever advances more than one counter.
- R7: A cycle with `issue_vld`, `dstall` and `imiss` all low adds nothing and leaves every counter unchanged. In such a cycle `slot_nop` is ignored.
- R8: A cycle presented at clock edge n shows in `energy_total` and in the counters after edge n+1, a latency of two edges.
- R9: The energy total saturates at 2^ACC_W−1 and stays there until cleared. It never decreases except on a clear.
- R10: When `clr` is high at an edge, the total and all counters read zero after that edge. The cycle presented with `clr` and a cycle still inside the block are not charged. The coefficients keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of total and counters |
| issue_vld | input | 1 | A bundle issues this cycle |
| slot_nop | input | SLOTS (4) | Per-slot NOP flag, bit i for slot i |
| dstall | input | 1 | Pipeline frozen by a data-side miss |
| imiss | input | 1 | Fetch-miss cycle with injected empty bundle |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 2 | Coefficient select |
| cfg_wdata | input | COEF_W (16) | Coefficient write value |
| energy_total | output | ACC_W (48) | Accumulated energy |
| ideal_cnt | output | CNT_W (32) | Issued-bundle cycle count |
| stall_cnt | output | CNT_W (32) | Stall cycle count |
| imiss_cnt | output | CNT_W (32) | Fetch-miss cycle count |

## Verification
The bench sends bundles with NOP masks of weight zero to four, including non-adjacent patterns. This separates a correct operation count from one that ignores slot position or the polarity of the flags. Stall and fetch-miss cycles are driven both with and without a valid bundle, and with both flags high together. This shows that each flag, and not `issue_vld`, chooses the charge, and that stall wins the tie. Idle cycles carry random NOP masks, coefficient writes land in the same cycle as a bundle, and clears arrive with activity still in the block. A second instance with a 20-bit total is driven past its limit so that it reaches and holds saturation. A long random mix ties all of these together.

// File: rtl/bem_pkg.sv
package bem_pkg;

  // Kind of a sampled core cycle; order is also the counter index + 1
  typedef enum logic [1:0] {
    CAT_IDLE  = 2'd0,
    CAT_IDEAL = 2'd1,
    CAT_STALL = 2'd2,
    CAT_IMISS = 2'd3
  } cyc_cat_e;

  // Coefficient slots in the write port
  localparam int unsigned COEF_BASE  = 0;
  localparam int unsigned COEF_SYL   = 1;
  localparam int unsigned COEF_STALL = 2;
  localparam int unsigned COEF_IMISS = 3;
  localparam int unsigned NUM_COEF   = 4;
  localparam int unsigned NUM_CNT    = 3;

endpackage

// File: rtl/bem_coef_bank.sv
module bem_coef_bank #(
  parameter int unsigned COEF_W = 16,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [COEF_W-1:0] wdata,
  output logic [COEF_W-1:0] base_o,
  output logic [COEF_W-1:0] syl_o,
  output logic [COEF_W-1:0] stall_o,
  output logic [COEF_W-1:0] miss_o
);
  import bem_pkg::*;

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [COEF_W-1:0] coef_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) coef_q[i] <= '0;
    end else if (we) begin
      coef_q[addr] <= wdata;
    end
  end

  assign base_o  = coef_q[COEF_BASE];
  assign syl_o   = coef_q[COEF_SYL];
  assign stall_o = coef_q[COEF_STALL];
  assign miss_o  = coef_q[COEF_IMISS];

endmodule

// File: rtl/bem_cycle_cost.sv
module bem_cycle_cost #(
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned COST_W = COEF_W + $clog2(SLOTS + 2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 issue_vld,
  input  logic [SLOTS-1:0]     slot_nop,
  input  logic                 dstall,
  input  logic                 imiss,
  input  logic [COEF_W-1:0]    base_i,
  input  logic [COEF_W-1:0]    syl_i,
  input  logic [COEF_W-1:0]    stall_i,
  input  logic [COEF_W-1:0]    miss_i,
  output bem_pkg::cyc_cat_e    cat_q,
  output logic [COST_W-1:0]    cost_q
);
  import bem_pkg::*;

  localparam int unsigned NZ_W = $clog2(SLOTS + 1);

  logic [NZ_W-1:0]   live_ops;
  logic [COST_W-1:0] bundle_cost;
  cyc_cat_e          cat_d;
  logic [COST_W-1:0] cost_d;

  // Count of slots holding a real operation
  always_comb begin
    live_ops = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!slot_nop[i]) live_ops = live_ops + NZ_W'(1);
    end
  end

  assign bundle_cost = COST_W'(base_i) + COST_W'(live_ops) * COST_W'(syl_i);

  // Stall outranks fetch miss, which outranks issue
  always_comb begin
    if (dstall) begin
      cat_d  = CAT_STALL;
      cost_d = COST_W'(stall_i);
    end else if (imiss) begin
      cat_d  = CAT_IMISS;
      cost_d = COST_W'(miss_i);
    end else if (issue_vld) begin
      cat_d  = CAT_IDEAL;
      cost_d = bundle_cost;
    end else begin
      cat_d  = CAT_IDLE;
      cost_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cat_q  <= CAT_IDLE;
      cost_q <= '0;
    end else begin
      cat_q  <= cat_d;
      cost_q <= cost_d;
    end
  end

endmodule

// File: rtl/bem_sat_accum.sv
module bem_sat_accum #(
  parameter int unsigned ACC_W  = 48,
  parameter int unsigned COST_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [COST_W-1:0] cost_i,
  output logic [ACC_W-1:0]  acc_q
);

  logic [ACC_W:0] sum;

  assign sum = {1'b0, acc_q} + (ACC_W + 1)'(cost_i);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
    end else if (sum[ACC_W]) begin
      acc_q <= '1;
    end else begin
      acc_q <= sum[ACC_W-1:0];
    end
  end

endmodule

// File: rtl/bem_cycle_counters.sv
module bem_cycle_counters #(
  parameter int unsigned CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  bem_pkg::cyc_cat_e   cat_i,
  output logic [CNT_W-1:0]    ideal_o,
  output logic [CNT_W-1:0]    stall_o,
  output logic [CNT_W-1:0]    imiss_o
);
  import bem_pkg::*;

  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        cnt_q[g] <= '0;
      end else if (cat_i == cyc_cat_e'(2'(g + 1))) begin
        cnt_q[g] <= cnt_q[g] + CNT_W'(1);
      end
    end
  end

  assign ideal_o = cnt_q[0];
  assign stall_o = cnt_q[1];
  assign imiss_o = cnt_q[2];

endmodule

// File: rtl/bundle_energy_meter.sv
module bundle_energy_meter #(
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned ACC_W  = 48,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              issue_vld,
  input  logic [SLOTS-1:0]  slot_nop,
  input  logic              dstall,
  input  logic              imiss,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [COEF_W-1:0] cfg_wdata,
  output logic [ACC_W-1:0]  energy_total,
  output logic [CNT_W-1:0]  ideal_cnt,
  output logic [CNT_W-1:0]  stall_cnt,
  output logic [CNT_W-1:0]  imiss_cnt
);
  import bem_pkg::*;

  localparam int unsigned COST_W = COEF_W + $clog2(SLOTS + 2);

  logic [COEF_W-1:0] c_base, c_syl, c_stall, c_miss;
  cyc_cat_e          cat_s1;
  logic [COST_W-1:0] cost_s1;

  bem_coef_bank #(.COEF_W(COEF_W), .ADDR_W(2)) u_coef (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .base_o  (c_base),
    .syl_o   (c_syl),
    .stall_o (c_stall),
    .miss_o  (c_miss)
  );

  bem_cycle_cost #(.SLOTS(SLOTS), .COEF_W(COEF_W), .COST_W(COST_W)) u_cost (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .issue_vld (issue_vld),
    .slot_nop  (slot_nop),
    .dstall    (dstall),
    .imiss     (imiss),
    .base_i    (c_base),
    .syl_i     (c_syl),
    .stall_i   (c_stall),
    .miss_i    (c_miss),
    .cat_q     (cat_s1),
    .cost_q    (cost_s1)
  );

  bem_sat_accum #(.ACC_W(ACC_W), .COST_W(COST_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .cost_i (cost_s1),
    .acc_q  (energy_total)
  );

  bem_cycle_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .cat_i   (cat_s1),
    .ideal_o (ideal_cnt),
    .stall_o (stall_cnt),
    .imiss_o (imiss_cnt)
  );

endmodule

// File: rtl/bem_checker.sv
module bem_checker #(
  parameter int unsigned ACC_W = 48,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             issue_vld,
  input logic             dstall,
  input logic             imiss,
  input logic [ACC_W-1:0] energy_total,
  input logic [CNT_W-1:0] ideal_cnt,
  input logic [CNT_W-1:0] stall_cnt,
  input logic [CNT_W-1:0] imiss_cnt
);

  // Edges seen since reset, saturating at 2
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  assert_clear_zero_R10: assert property (@(posedge clk) disable iff (rst || age == 2'd0)
    $past(clr) |-> (energy_total == '0 && ideal_cnt == '0 && stall_cnt == '0 && imiss_cnt == '0));

  assert_no_decrease_R9: assert property (@(posedge clk) disable iff (rst || age == 2'd0)
    !$past(clr) |-> energy_total >= $past(energy_total));

  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (rst || age == 2'd0)
    ($past(energy_total) == {ACC_W{1'b1}} && !$past(clr)) |-> energy_total == {ACC_W{1'b1}});

  assert_one_counter_R6: assert property (@(posedge clk) disable iff (rst || age == 2'd0)
    !$past(clr) |-> $countones({ideal_cnt != $past(ideal_cnt), stall_cnt != $past(stall_cnt),
                                imiss_cnt != $past(imiss_cnt)}) <= 1);

  assert_stall_wins_R6: assert property (@(posedge clk) disable iff (rst || age != 2'd2)
    ($past(dstall, 2) && !$past(clr, 2) && !$past(clr)) |->
      (stall_cnt == $past(stall_cnt) + CNT_W'(1) && imiss_cnt == $past(imiss_cnt)
       && ideal_cnt == $past(ideal_cnt)));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst || age != 2'd2)
    (!$past(issue_vld, 2) && !$past(dstall, 2) && !$past(imiss, 2) && !$past(clr, 2) && !$past(clr)) |->
      (energy_total == $past(energy_total) && ideal_cnt == $past(ideal_cnt)
       && stall_cnt == $past(stall_cnt) && imiss_cnt == $past(imiss_cnt)));

endmodule

bind bundle_energy_meter bem_checker #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .clr          (clr),
  .issue_vld    (issue_vld),
  .dstall       (dstall),
  .imiss        (imiss),
  .energy_total (energy_total),
  .ideal_cnt    (ideal_cnt),
  .stall_cnt    (stall_cnt),
  .imiss_cnt    (imiss_cnt)
);

// File: tb/bundle_energy_meter_tb.sv
module bundle_energy_meter_tb;

  localparam int unsigned SAT_W = 20;
  localparam longint unsigned SAT_MAX = (64'd1 << SAT_W) - 1;

  typedef struct packed {
    logic [1:0]  cat;
    logic [31:0] cost;
    logic        clr;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic        issue_vld = 1'b0;
  logic [3:0]  slot_nop = 4'h0;
  logic        dstall = 1'b0;
  logic        imiss = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic [47:0] energy_total;
  logic [31:0] ideal_cnt, stall_cnt, imiss_cnt;
  logic [SAT_W-1:0] sat_total;
  logic [31:0] sat_ideal, sat_stall, sat_imiss;

  always #2.5 clk = ~clk;

  bundle_energy_meter u_dut (
    .clk(clk), .rst(rst), .clr(clr), .issue_vld(issue_vld), .slot_nop(slot_nop),
    .dstall(dstall), .imiss(imiss), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .energy_total(energy_total), .ideal_cnt(ideal_cnt),
    .stall_cnt(stall_cnt), .imiss_cnt(imiss_cnt)
  );

  bundle_energy_meter #(.ACC_W(SAT_W)) u_dut_sat (
    .clk(clk), .rst(rst), .clr(clr), .issue_vld(issue_vld), .slot_nop(slot_nop),
    .dstall(dstall), .imiss(imiss), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .energy_total(sat_total), .ideal_cnt(sat_ideal),
    .stall_cnt(sat_stall), .imiss_cnt(sat_imiss)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  bit    mon_on = 1'b0;
  string phase = "R1";
  item_t q[$];
  longint unsigned coef_m [4];
  longint unsigned exp_e, exp_sat;
  longint unsigned exp_cnt [3];
  item_t pending;

  task automatic chk(input string tag, input string what, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: one call per clock; computes the expected charge from the requirements
  task automatic drive(input logic v, input logic [3:0] n, input logic s, input logic m,
                       input logic c, input logic we, input logic [1:0] a,
                       input logic [15:0] d);
    item_t it;
    int k;
    @(negedge clk);
    issue_vld = v; slot_nop = n; dstall = s; imiss = m; clr = c;
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    k = 0;
    for (int i = 0; i < 4; i++) if (!n[i]) k++;
    it.clr = c;
    if (s) begin it.cat = 2'd2; it.cost = 32'(coef_m[2]); end
    else if (m) begin it.cat = 2'd3; it.cost = 32'(coef_m[3]); end
    else if (v) begin it.cat = 2'd1; it.cost = 32'(coef_m[0] + longint'(k) * coef_m[1]); end
    else begin it.cat = 2'd0; it.cost = 32'd0; end
    q.push_back(it);
    if (we) coef_m[a] = longint'(d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 4'h0, 0, 0, 0, 0, 2'd0, 16'd0);
  endtask

  task automatic bundle(input logic [3:0] n);
    drive(1, n, 0, 0, 0, 0, 2'd0, 16'd0);
  endtask

  task automatic wcoef(input logic [1:0] a, input logic [15:0] d);
    drive(0, 4'h0, 0, 0, 0, 1, a, d);
  endtask

  // Monitor: applies the charge captured one edge earlier (R8 latency) and compares
  always begin
    item_t got;
    @(posedge clk);
    #1;
    if (mon_on && !done) begin
      got = (q.size() > 0) ? q.pop_front() : item_t'(0);
      if (got.clr) begin
        exp_e = 0; exp_sat = 0;
        for (int i = 0; i < 3; i++) exp_cnt[i] = 0;
        pending = item_t'(0);
      end else begin
        exp_e = exp_e + longint'(pending.cost);
        exp_sat = exp_sat + longint'(pending.cost);
        if (exp_sat > SAT_MAX) exp_sat = SAT_MAX;
        if (pending.cat != 2'd0) exp_cnt[pending.cat - 1] = exp_cnt[pending.cat - 1] + 1;
        pending = got;
      end
      chk(phase, "energy_total", longint'(energy_total), exp_e);
      chk(phase, "ideal_cnt", longint'(ideal_cnt), exp_cnt[0]);
      chk(phase, "stall_cnt", longint'(stall_cnt), exp_cnt[1]);
      chk(phase, "imiss_cnt", longint'(imiss_cnt), exp_cnt[2]);
      chk(phase, "sat_total", longint'(sat_total), exp_sat);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) coef_m[i] = 0;
    exp_e = 0; exp_sat = 0;
    for (int i = 0; i < 3; i++) exp_cnt[i] = 0;
    pending = item_t'(0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "energy_total", longint'(energy_total), 0);
    chk("R1", "ideal_cnt", longint'(ideal_cnt), 0);
    chk("R1", "stall_cnt", longint'(stall_cnt), 0);
    chk("R1", "imiss_cnt", longint'(imiss_cnt), 0);
    rst = 1'b0;
    mon_on = 1'b1;
    // R1: zero coefficients after reset, a bundle costs nothing
    bundle(4'h0); drive(0, 4'h0, 1, 0, 0, 0, 2'd0, 16'd0); idle(2);

    phase = "R2";
    wcoef(2'd0, 16'd100); wcoef(2'd1, 16'd7); wcoef(2'd2, 16'd40); wcoef(2'd3, 16'd25);
    bundle(4'h0);
    // write in the same cycle as a bundle: bundle uses old base 100
    drive(1, 4'h0, 0, 0, 0, 1, 2'd0, 16'd200);
    bundle(4'h0); idle(2);

    phase = "R3";
    bundle(4'hF); bundle(4'h5); bundle(4'hA); bundle(4'hE); bundle(4'h1); bundle(4'h6);
    bundle(4'h0); idle(2);

    phase = "R4";
    drive(1, 4'h0, 1, 0, 0, 0, 2'd0, 16'd0);
    drive(0, 4'h3, 1, 0, 0, 0, 2'd0, 16'd0);
    drive(1, 4'hF, 1, 0, 0, 0, 2'd0, 16'd0); idle(2);

    phase = "R5";
    drive(1, 4'h0, 0, 1, 0, 0, 2'd0, 16'd0);
    drive(0, 4'hF, 0, 1, 0, 0, 2'd0, 16'd0); idle(2);

    phase = "R6";
    drive(1, 4'h0, 1, 1, 0, 0, 2'd0, 16'd0);
    drive(0, 4'h9, 1, 1, 0, 0, 2'd0, 16'd0); idle(2);

    phase = "R7";
    drive(0, 4'h0, 0, 0, 0, 0, 2'd0, 16'd0);
    drive(0, 4'h7, 0, 0, 0, 0, 2'd0, 16'd0);
    drive(0, 4'hC, 0, 0, 0, 0, 2'd0, 16'd0); idle(2);

    phase = "R8";
    bundle(4'h8); idle(3); bundle(4'h2); bundle(4'h0); idle(3);

    phase = "R10";
    bundle(4'h0); drive(1, 4'h0, 0, 0, 1, 0, 2'd0, 16'd0); idle(2);
    bundle(4'h3); drive(0, 4'h0, 1, 0, 0, 0, 2'd0, 16'd0);
    drive(0, 4'h0, 0, 1, 1, 0, 2'd0, 16'd0); idle(1);
    bundle(4'h0); idle(2);

    phase = "R9";
    wcoef(2'd3, 16'hFFFF);
    for (int i = 0; i < 20; i++) drive(0, 4'h0, 0, 1, 0, 0, 2'd0, 16'd0);
    bundle(4'h0); idle(2);

    phase = "R3 R4 R5 R6 R7 R10 mix";
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[4:0] == 5'd0) drive(r[5], r[9:6], r[10], r[11], 1, 0, 2'd0, 16'd0);
      else if (r[4:0] == 5'd1) drive(r[5], r[9:6], r[10] & r[12], r[11] & r[13], 0, 1,
                                     r[15:14], r[31:16]);
      else drive(r[5], r[9:6], r[10] & r[12], r[11] & r[13], 0, 0, 2'd0, 16'd0);
    end
    idle(4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule